// File: doc/BRIEF.md
# Burst Local Bus Master

This block sits between an upstream queue of word transfer requests and a 32-bit processor-style local bus, where it acts as the bus master. Each request gives a start byte address, a direction and a word count. The block turns the request into one or more bursts. Every burst opens with a single address-strobe cycle and is followed by data phases. Each data phase finishes only when the slave returns ready. The final data phase of every burst is flagged with a last-transfer signal.

A programmable register sets the maximum burst length, from 1 to 256 words. Requests longer than this limit are cut into back-to-back bursts, and each burst starts at the next word address. A slave may cut a burst short by asserting an early-terminate input on any data phase. The master then issues a fresh address strobe and resumes at the first word that has not completed. Data-phase timing comes only from the slave's ready signal, because the master has no wait-state generator of its own. When the whole request is done, the block returns a one-cycle completion pulse upstream.

Top module: `burst_bus_master`

## Requirements
- R1: After reset, address strobe, last-transfer and done are low, req_ready is high, and the burst-length register holds 0 (meaning 256 words).
- R2: The cycle after a request is accepted, the address strobe is high for exactly one cycle and carries the start address and the direction. Data phases follow directly after it.
- R3: A data phase completes only on a clock edge where ready is sampled high. The address then advances by 4 bytes. While ready is low the address holds.
- R4: The last-transfer signal is high on the final data phase of every burst and on no other cycle. A one-word burst carries it on its only data phase.
- R5: A burst never holds more words than the burst-length register value taken at its address strobe. A value of 0 means 256 words.
- R6: A request longer than the limit is split into consecutive bursts. Each burst starts with an address strobe at the next word address. The request uses ceil(count/limit) strobes when it is not terminated early.
- R7: Early termination sampled without ready leaves that word incomplete. The next cycle shows an address strobe at that same word address.
- R8: Early termination sampled together with ready completes that word. The restart strobe then carries the following word address. If the word was the last one of the request, no restart occurs.
- R9: One cycle after the final word of a request completes, done pulses high for one cycle and req_ready is high again.
- R10: Each completed read word raises rd_valid_o with the bus read data in the same cycle. Each completed write word raises wr_pop_o while the bus write data equals the upstream write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the burst-length register |
| cfg_max_len | input | 8 | Maximum burst length, 0 means 256 |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Start byte address, word aligned |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_count | input | 16 | Number of words, must be nonzero |
| req_done | output | 1 | One-cycle pulse when the request has finished |
| wr_data_i | input | 32 | Upstream write word for the current phase |
| wr_pop_o | output | 1 | Write word consumed |
| rd_data_o | output | 32 | Read word returned upstream |
| rd_valid_o | output | 1 | Read word valid |
| bus_ads_o | output | 1 | Address strobe |
| bus_addr_o | output | 32 | Bus byte address |
| bus_write_o | output | 1 | Bus direction |
| bus_blast_o | output | 1 | Last transfer of the burst |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data |
| bus_ready_i | input | 1 | Slave ready, ends a data phase |
| bus_bterm_i | input | 1 | Slave early burst termination |

## Verification
Two things can land on the same data phase: the slave's early-termination request and the word's own completion by ready. Either of them may also fall on the burst's last-transfer word. The bench asserts termination on a chosen data phase in three cases: with ready low, with ready high in the middle of a burst, and with ready high on the last word of a burst. It then checks the address carried by the restart strobe and the total number of strobes against values worked out from R6 to R8.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bbm_state_e;

endpackage

// File: rtl/bbm_len_reg.sv
module bbm_len_reg #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_max_len,
    output logic [LEN_W:0]   eff_len
);

    typedef struct packed {
        logic [LEN_W-1:0] len;
    } len_reg_t;

    len_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            r_d.len = cfg_max_len;
        end
        // zero encodes the largest burst
        eff_len = (r_q.len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, r_q.len};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W:0]    eff_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_done,
    input  logic              bus_ready_i,
    input  logic              bus_bterm_i,
    output logic              bus_ads_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_write_o,
    output logic              bus_blast_o,
    output logic              in_data
);

    localparam int STEP = DATA_W / 8;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STEP);

    typedef struct packed {
        bbm_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic [LEN_W:0]    blen;
        logic              write;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [LEN_W:0] clamp_len(input logic [CNT_W-1:0] rem,
                                                 input logic [LEN_W:0]   lim);
        if (rem < CNT_W'(lim)) begin
            return (LEN_W+1)'(rem);
        end
        return lim;
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr  = req_addr;
                    s_d.rem   = req_count;
                    s_d.write = req_write;
                    s_d.blen  = clamp_len(req_count, eff_len);
                    s_d.state = ST_ADDR;
                end
            end
            ST_ADDR: begin
                s_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ready_i) begin
                    s_d.addr = s_q.addr + ADDR_STEP;
                    s_d.rem  = s_q.rem - 1'b1;
                    s_d.blen = s_q.blen - 1'b1;
                    if (s_q.rem == CNT_W'(1)) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end else if (s_q.blen == (LEN_W+1)'(1) || bus_bterm_i) begin
                        s_d.state = ST_ADDR;
                        s_d.blen  = clamp_len(s_q.rem - 1'b1, eff_len);
                    end
                end else if (bus_bterm_i) begin
                    // word not taken: restart at the same address
                    s_d.state = ST_ADDR;
                    s_d.blen  = clamp_len(s_q.rem, eff_len);
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.state == ST_IDLE);
    assign req_done    = s_q.done;
    assign bus_ads_o   = (s_q.state == ST_ADDR);
    assign in_data     = (s_q.state == ST_DATA);
    assign bus_addr_o  = s_q.addr;
    assign bus_write_o = s_q.write;
    assign bus_blast_o = in_data && (s_q.blen == (LEN_W+1)'(1));

endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_done,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_pop_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              bus_ads_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_write_o,
    output logic              bus_blast_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ready_i,
    input  logic              bus_bterm_i
);

    logic [LEN_W:0] eff_len;
    logic           in_data;

    bbm_len_reg #(.LEN_W(LEN_W)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_max_len (cfg_max_len),
        .eff_len     (eff_len)
    );

    bbm_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_len     (eff_len),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_count   (req_count),
        .req_done    (req_done),
        .bus_ready_i (bus_ready_i),
        .bus_bterm_i (bus_bterm_i),
        .bus_ads_o   (bus_ads_o),
        .bus_addr_o  (bus_addr_o),
        .bus_write_o (bus_write_o),
        .bus_blast_o (bus_blast_o),
        .in_data     (in_data)
    );

    assign bus_wdata_o = wr_data_i;
    assign wr_pop_o    = in_data && bus_ready_i && bus_write_o;
    assign rd_valid_o  = in_data && bus_ready_i && !bus_write_o;
    assign rd_data_o   = bus_rdata_i;

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_data,
    input logic              ads,
    input logic              blast,
    input logic              ready,
    input logic              bterm,
    input logic              wr,
    input logic              done,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);

    p_ads_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ads |=> (!ads && in_data));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && ready) |=> (addr == $past(addr) + STEP4));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !ready) |=> $stable(addr));

    p_blast_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && ready && blast) |=> !in_data);

    p_bterm_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && bterm) |=> (ads || done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (in_data && ready && !wr));

endmodule

bind burst_bus_master bbm_checker #(.ADDR_W(ADDR_W)) u_bbm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .ads       (bus_ads_o),
    .blast     (bus_blast_o),
    .ready     (bus_ready_i),
    .bterm     (bus_bterm_i),
    .wr        (bus_write_o),
    .done      (req_done),
    .req_ready (req_ready),
    .rd_valid  (rd_valid_o),
    .addr      (bus_addr_o)
);

// File: tb/tb_burst_bus_master.sv
module tb_burst_bus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_max_len = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_count = '0;
    logic        req_done;
    logic [31:0] wr_data_i = '0;
    logic        wr_pop_o;
    logic [31:0] rd_data_o;
    logic        rd_valid_o;
    logic        bus_ads_o;
    logic [31:0] bus_addr_o;
    logic        bus_write_o;
    logic        bus_blast_o;
    logic [31:0] bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        bus_ready_i = 1'b0;
    logic        bus_bterm_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int cur_max = 256;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    burst_bus_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_max_len(cfg_max_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_count(req_count), .req_done(req_done),
        .wr_data_i(wr_data_i), .wr_pop_o(wr_pop_o), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .bus_ads_o(bus_ads_o), .bus_addr_o(bus_addr_o),
        .bus_write_o(bus_write_o), .bus_blast_o(bus_blast_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
        .bus_ready_i(bus_ready_i), .bus_bterm_i(bus_bterm_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic program_len(input int len);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_max_len = 8'(len);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_max = (len == 0) ? 256 : len;
    endtask

    // one request; slave inserts ws wait cycles per word; bterm on data cycle bt_idx
    task automatic run_xfer(input string nm, input logic [31:0] a, input int cnt,
                            input bit w, input int ws, input int bt_idx,
                            input bit bt_rdy, input int exp_ads);
        logic [31:0] m_addr;
        int m_rem, m_blen, dcyc, ads_seen, words, wcnt;
        bit exp_ads_now, fin;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_count = 16'(cnt);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        m_addr = a; m_rem = cnt; m_blen = 0; dcyc = 0; ads_seen = 0;
        words = 0; wcnt = 0; exp_ads_now = 1'b1; fin = 1'b0;
        for (int c = 0; c < 5000 && !fin; c++) begin
            if (exp_ads_now) begin
                chk(bus_ads_o == 1'b1, "R2", {nm, " strobe"}, bus_ads_o, 1);
                chk(bus_addr_o == m_addr, "R2/R7/R8", {nm, " strobe addr"}, bus_addr_o, m_addr);
                chk(bus_write_o == w, "R2", {nm, " dir"}, bus_write_o, w);
                chk(bus_blast_o == 1'b0, "R4", {nm, " blast on strobe"}, bus_blast_o, 0);
                if (bus_ads_o) ads_seen++;
                m_blen = (m_rem < cur_max) ? m_rem : cur_max;
                exp_ads_now = 1'b0;
                bus_ready_i = 1'b0; bus_bterm_i = 1'b0;
            end else begin
                bit rdy, bt;
                rdy = (ws == 0) || ((wcnt % (ws + 1)) == ws);
                bt = (dcyc == bt_idx);
                if (bt) rdy = bt_rdy;
                bus_ready_i = rdy; bus_bterm_i = bt;
                wr_data_i = 32'hA000_0000 + 32'(words);
                bus_rdata_i = m_addr ^ 32'h5555_0000;
                #1;
                chk(bus_ads_o == 1'b0, "R2", {nm, " no strobe in data"}, bus_ads_o, 0);
                chk(bus_addr_o == m_addr, "R3", {nm, " data addr"}, bus_addr_o, m_addr);
                chk(bus_blast_o == (m_blen == 1), "R4/R5", {nm, " blast"}, bus_blast_o, m_blen == 1);
                if (w) begin
                    chk(wr_pop_o == rdy, "R10", {nm, " pop"}, wr_pop_o, rdy);
                    chk(bus_wdata_o == wr_data_i, "R10", {nm, " wdata"}, bus_wdata_o, wr_data_i);
                end else begin
                    chk(rd_valid_o == rdy, "R10", {nm, " rd_valid"}, rd_valid_o, rdy);
                    if (rdy) chk(rd_data_o == (m_addr ^ 32'h5555_0000), "R10", {nm, " rdata"},
                                 rd_data_o, m_addr ^ 32'h5555_0000);
                end
                if (rdy) begin
                    m_addr += 4; m_rem--; m_blen--; words++; wcnt = 0;
                    if (m_rem == 0) fin = 1'b1;
                    else if (m_blen == 0 || bt) exp_ads_now = 1'b1;
                end else begin
                    wcnt++;
                    if (bt) exp_ads_now = 1'b1;
                end
                dcyc++;
            end
            @(negedge clk);
        end
        bus_ready_i = 1'b0; bus_bterm_i = 1'b0;
        chk(fin, "R3", {nm, " completed"}, fin, 1);
        chk(req_done == 1'b1, "R9", {nm, " done pulse"}, req_done, 1);
        chk(req_ready == 1'b1, "R9", {nm, " ready back"}, req_ready, 1);
        chk(bus_ads_o == 1'b0, "R8", {nm, " no restart after last"}, bus_ads_o, 0);
        chk(words == cnt, "R3", {nm, " words"}, words, cnt);
        chk(ads_seen == exp_ads, "R6", {nm, " strobe count"}, ads_seen, exp_ads);
        @(negedge clk);
        chk(req_done == 1'b0, "R9", {nm, " done one cycle"}, req_done, 0);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(bus_ads_o == 1'b0, "R1", "ads", bus_ads_o, 0);
        chk(bus_blast_o == 1'b0, "R1", "blast", bus_blast_o, 0);
        chk(req_done == 1'b0, "R1", "done", req_done, 0);
    endtask

    task automatic t_default_256;
        // R1/R5: reset value 0 gives 256-word bursts; 300 words -> 2 strobes
        run_xfer("reset_len_300", 32'h0001_0000, 300, 1'b0, 0, -1, 1'b0, 2);
    endtask

    task automatic t_single;
        program_len(0);
        run_xfer("single", 32'h0000_1000, 1, 1'b0, 0, -1, 1'b0, 1);   // R4
    endtask

    task automatic t_split;
        program_len(4);
        run_xfer("split_wr", 32'h0000_2000, 6, 1'b1, 1, -1, 1'b0, 2); // R6
        program_len(1);
        run_xfer("len1", 32'h0000_3000, 3, 1'b0, 2, -1, 1'b0, 3);     // R5
    endtask

    task automatic t_bterm;
        program_len(8);
        run_xfer("bterm_norr", 32'h0000_4000, 5, 1'b0, 0, 2, 1'b0, 2);  // R7
        run_xfer("bterm_rdy", 32'h0000_5000, 5, 1'b1, 0, 2, 1'b1, 2);   // R8
        run_xfer("bterm_last", 32'h0000_6000, 3, 1'b0, 0, 2, 1'b1, 1);  // R8 final word
        program_len(4);
        run_xfer("bterm_blast", 32'h0000_7000, 8, 1'b0, 0, 3, 1'b1, 2); // R8 on blast word
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_256();
        t_single();
        t_split();
        t_bterm();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule